// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the network layer of a single-wire bus slave. A bit-slot front end below it turns line activity into three strobes: a bus reset event, a bit written by the master, and a read slot in which the slave may answer. The block holds no timing of its own. It counts strobes, decodes the 8-bit ROM command and walks a 64-bit identity for reading, matching or the bitwise search. When addressing succeeds, it raises a select level that hands the bus to a memory-command layer above it.

In a read slot the block answers by requesting a pull-down (`drive_low_o` high, meaning a 0 is sent) or by leaving the line released (a 1 is sent). Several slaves on one line therefore combine as a wired-AND. A slave that loses arbitration, fails a match or receives an unknown command falls silent until the next bus reset. The identity word and an alarm flag come in as inputs.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst`, `select_o` and `drive_low_o` are low. Until the first `bus_reset_i` pulse, written bits are ignored, so no command can select the block.
- R2: A `bus_reset_i` pulse in any state clears `select_o` on the next edge and restarts command reception. This includes a pulse in the middle of a transfer.
- R3: A command is the next 8 written bits after a bus reset, least significant bit first. The recognised values are 33h (read identity), 55h (match), CCh (skip), F0h (search) and ECh (alarm search).
- R4: After 33h, read slots present identity bits 0 to 63 in order, with bit 0 being the least significant bit of the 8-bit family code in `id_i[7:0]`. `select_o` rises after the 64th read slot.
- R5: After 55h, 64 written bits are compared with identity bits 0 to 63 in order. If all of them are equal, `select_o` rises on the edge that takes the 64th bit.
- R6: In a match, a written bit that differs from the identity bit silences the block until the next bus reset. It then never selects and leaves read slots released.
- R7: After CCh, `select_o` rises on the edge that takes the 8th command bit.
- R8: After F0h, each identity bit uses three slots: a read slot sending the bit, a read slot sending its complement, then a written direction bit. If every direction bit equals the identity bit, `select_o` rises after the 64th direction bit.
- R9: In a search, a direction bit that differs from the identity bit drops the block out until the next bus reset. Later read slots are released and `select_o` stays low.
- R10: ECh behaves exactly as F0h when `alarm_i` is high as the command completes. Otherwise the block stays silent until the next bus reset.
- R11: Any other command byte makes the block silent (released, never selected) until the next bus reset.
- R12: `drive_low_o` is high only in a sending phase whose bit is 0. It is low whenever `select_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: the front end saw a master reset |
| wr_valid_i | input | 1 | One-cycle pulse: the master wrote a bit |
| wr_bit_i | input | 1 | Value of the written bit, valid with `wr_valid_i` |
| rd_req_i | input | 1 | One-cycle pulse: a read slot is being serviced and consumed |
| id_i | input | 64 | Identity word, bit 0 sent first |
| alarm_i | input | 1 | Alarm condition from the measurement side |
| drive_low_o | output | 1 | Request to pull the line low in the current read slot |
| select_o | output | 1 | Addressing succeeded; memory layer owns the bus |

## Verification
State, cursor and `select_o` change on the same clock edge that samples a strobe, so a result is due one edge after the strobe that causes it. `drive_low_o` is decoded from that registered state. It therefore already holds the answer for a read slot during the cycle in which `rd_req_i` is raised, and the front end samples it there. The bench drives every strobe on the falling edge for exactly one cycle. It reads `drive_low_o` in that same half-cycle, before the consuming edge, and checks `select_o` on the falling edge after the last strobe of a sequence.

// File: rtl/owr_pkg.sv
package owr_pkg;

    localparam int ID_W_DEF = 64;
    localparam int CMD_W    = 8;

    localparam logic [CMD_W-1:0] OP_READ_ID = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH   = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP    = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH  = 8'hF0;
    localparam logic [CMD_W-1:0] OP_ALARM   = 8'hEC;

    typedef enum logic [3:0] {
        ST_WAIT_RST,
        ST_CMD,
        ST_READ_ID,
        ST_MATCH,
        ST_SRCH_BIT,
        ST_SRCH_CMP,
        ST_SRCH_DIR,
        ST_SELECTED,
        ST_MUTE
    } owr_state_e;

    typedef struct packed {
        logic bus_rst;
        logic wr;
        logic wbit;
        logic rd;
    } owr_slot_t;

    function automatic owr_state_e decode_op(input logic [CMD_W-1:0] op,
                                             input logic alarm);
        owr_state_e nxt;
        case (op)
            OP_READ_ID: nxt = ST_READ_ID;
            OP_MATCH:   nxt = ST_MATCH;
            OP_SKIP:    nxt = ST_SELECTED;
            OP_SEARCH:  nxt = ST_SRCH_BIT;
            OP_ALARM:   nxt = alarm ? ST_SRCH_BIT : ST_MUTE;
            default:    nxt = ST_MUTE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/owr_cmd_rx.sv
module owr_cmd_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic         done_o,
    output logic [W-1:0] byte_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-2:0]  sr;
    logic [CW-1:0] cnt;

    // LSB first: the newest bit enters at the top
    assign byte_o = {bit_i, sr};
    assign done_o = shift_en && (cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sr  <= byte_o[W-1:1];
            cnt <= done_o ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owr_id_cursor.sv
module owr_id_cursor #(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            adv,
    input  logic [ID_W-1:0] id_i,
    output logic            bit_o,
    output logic            last_o
);
    localparam int IDX_W = $clog2(ID_W);

    logic [IDX_W-1:0] idx;

    assign bit_o  = id_i[idx];
    assign last_o = (idx == IDX_W'(ID_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (adv)
            idx <= last_o ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
    import owr_pkg::*;
#(
    parameter int ID_W = owr_pkg::ID_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_reset_i,
    input  logic            wr_valid_i,
    input  logic            wr_bit_i,
    input  logic            rd_req_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            alarm_i,
    output logic            drive_low_o,
    output logic            select_o
);
    owr_slot_t        slot;
    owr_state_e       state, state_nxt;
    logic             cmd_en, cmd_done;
    logic [CMD_W-1:0] cmd_byte;
    logic             cur_adv, id_bit, id_last;
    logic             bit_ok;

    assign slot = '{bus_rst: bus_reset_i, wr: wr_valid_i,
                    wbit: wr_bit_i, rd: rd_req_i};

    assign cmd_en = (state == ST_CMD) && slot.wr && !slot.bus_rst;
    assign bit_ok = (slot.wbit == id_bit);

    owr_cmd_rx #(.W(CMD_W)) cmd_rx_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (slot.bus_rst),
        .shift_en (cmd_en),
        .bit_i    (slot.wbit),
        .done_o   (cmd_done),
        .byte_o   (cmd_byte)
    );

    always_comb begin
        cur_adv = 1'b0;
        case (state)
            ST_READ_ID:  cur_adv = slot.rd;
            ST_MATCH,
            ST_SRCH_DIR: cur_adv = slot.wr && bit_ok;
            default:     cur_adv = 1'b0;
        endcase
    end

    owr_id_cursor #(.ID_W(ID_W)) cursor_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (slot.bus_rst),
        .adv    (cur_adv && !slot.bus_rst),
        .id_i   (id_i),
        .bit_o  (id_bit),
        .last_o (id_last)
    );

    always_comb begin
        state_nxt = state;
        if (slot.bus_rst) begin
            state_nxt = ST_CMD;
        end else begin
            case (state)
                ST_CMD:
                    if (cmd_done) state_nxt = decode_op(cmd_byte, alarm_i);
                ST_READ_ID:
                    if (slot.rd && id_last) state_nxt = ST_SELECTED;
                ST_MATCH:
                    if (slot.wr) begin
                        if (!bit_ok)      state_nxt = ST_MUTE;
                        else if (id_last) state_nxt = ST_SELECTED;
                    end
                ST_SRCH_BIT:
                    if (slot.rd) state_nxt = ST_SRCH_CMP;
                ST_SRCH_CMP:
                    if (slot.rd) state_nxt = ST_SRCH_DIR;
                ST_SRCH_DIR:
                    if (slot.wr) begin
                        if (!bit_ok)      state_nxt = ST_MUTE;
                        else if (id_last) state_nxt = ST_SELECTED;
                        else              state_nxt = ST_SRCH_BIT;
                    end
                default: state_nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT_RST;
        else     state <= state_nxt;
    end

    // A pull-down request sends 0; released line sends 1
    always_comb begin
        case (state)
            ST_READ_ID,
            ST_SRCH_BIT: drive_low_o = !id_bit;
            ST_SRCH_CMP: drive_low_o = id_bit;
            default:     drive_low_o = 1'b0;
        endcase
    end

    assign select_o = (state == ST_SELECTED);
endmodule

// File: rtl/owr_rom_layer_chk.sv
module owr_rom_layer_chk (
    input logic clk,
    input logic rst,
    input logic bus_reset_i,
    input logic wr_valid_i,
    input logic rd_req_i,
    input logic drive_low_o,
    input logic select_o
);
    logic seen_bus_rst;

    always_ff @(posedge clk) begin
        if (rst)              seen_bus_rst <= 1'b0;
        else if (bus_reset_i) seen_bus_rst <= 1'b1;
    end

    p_quiet_before_reset_r1: assert property (@(posedge clk) disable iff (rst)
        !seen_bus_rst |-> (!select_o && !drive_low_o));

    p_sel_clear_r2: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |=> !select_o);

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (select_o && !bus_reset_i) |=> select_o);

    // R5, R7: select rises only on the edge that took a master slot
    p_sel_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(select_o) |-> $past(wr_valid_i || rd_req_i));

    p_release_sel_r12: assert property (@(posedge clk) disable iff (rst)
        select_o |-> !drive_low_o);
endmodule

bind owr_rom_layer owr_rom_layer_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_reset_i (bus_reset_i),
    .wr_valid_i  (wr_valid_i),
    .rd_req_i    (rd_req_i),
    .drive_low_o (drive_low_o),
    .select_o    (select_o)
);

// File: tb/owr_rom_layer_tb_top.sv
module owr_rom_layer_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] ID_VAL     = 64'hA53C_960F_1E2D_4B78;
    localparam int          NVEC       = 7;
    // {command, alarm, select after command, first read-slot value}
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h33, 1'b0, 1'b0, 1'b0},   // R4: id bit 0 is 0
        {8'hCC, 1'b0, 1'b1, 1'b1},   // R7
        {8'hF0, 1'b0, 1'b0, 1'b0},   // R8
        {8'hEC, 1'b1, 1'b0, 1'b0},   // R10 alarm set
        {8'hEC, 1'b0, 1'b0, 1'b1},   // R10 alarm clear
        {8'hA7, 1'b0, 1'b0, 1'b1},   // R11
        {8'h55, 1'b0, 1'b0, 1'b1}    // R5: match phase sends nothing
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic        wr_bit_i = 1'b0;
    logic        rd_req_i = 1'b0;
    logic [63:0] id_i = ID_VAL;
    logic        alarm_i = 1'b0;
    logic        drive_low_o;
    logic        select_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owr_rom_layer dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_i (bus_reset_i),
        .wr_valid_i  (wr_valid_i),
        .wr_bit_i    (wr_bit_i),
        .rd_req_i    (rd_req_i),
        .id_i        (id_i),
        .alarm_i     (alarm_i),
        .drive_low_o (drive_low_o),
        .select_o    (select_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_reset();
        @(negedge clk); bus_reset_i = 1'b1;
        @(negedge clk); bus_reset_i = 1'b0;
    endtask

    task automatic wr_slot(input logic b);
        @(negedge clk); wr_valid_i = 1'b1; wr_bit_i = b;
        @(negedge clk); wr_valid_i = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_slot(v[i]);
    endtask

    task automatic rd_slot(output logic b);
        @(negedge clk); rd_req_i = 1'b1; b = !drive_low_o;
        @(negedge clk); rd_req_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic        b, c;
        logic [63:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(select_o == 1'b0, "R1 select after rst", select_o, 0);
        check(drive_low_o == 1'b0, "R1 line after rst", drive_low_o, 0);
        // R1: skip command before any bus reset is ignored
        wr_byte(8'hCC);
        check(select_o == 1'b0, "R1 command before bus reset", select_o, 0);

        // R3: table walk over command bytes
        for (int k = 0; k < NVEC; k++) begin
            alarm_i = VEC[k][2];
            bus_reset();
            wr_byte(VEC[k][10:3]);
            check(select_o == VEC[k][1], "R3 select after command",
                  select_o, VEC[k][1]);
            rd_slot(b);
            check(b == VEC[k][0], "R3 first read slot", b, VEC[k][0]);
        end
        alarm_i = 1'b0;

        // R4: full identity read
        bus_reset();
        wr_byte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            rd_slot(b);
            got[i] = b;
        end
        check(got == ID_VAL, "R4 identity read", got, ID_VAL);
        check(select_o == 1'b1, "R4 select after read", select_o, 1);
        // R12: released while selected
        rd_slot(b);
        check(b == 1'b1, "R12 released when selected", b, 1);
        // R2: bus reset clears select
        bus_reset();
        check(select_o == 1'b0, "R2 select cleared", select_o, 0);

        // R5: full match
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_slot(ID_VAL[i]);
        check(select_o == 1'b1, "R5 match selects", select_o, 1);

        // R6: mismatch at bit 40
        bus_reset();
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr_slot(i == 40 ? !ID_VAL[i] : ID_VAL[i]);
        check(select_o == 1'b0, "R6 mismatch no select", select_o, 0);
        rd_slot(b);
        check(b == 1'b1, "R6 mismatch released", b, 1);

        // R2: bus reset mid-match restarts command reception
        bus_reset();
        wr_byte(8'h55);
        for (int i = 0; i < 10; i++) wr_slot(ID_VAL[i]);
        bus_reset();
        wr_byte(8'hCC);
        check(select_o == 1'b1, "R2 reset mid transfer", select_o, 1);

        // R8: full search pass
        bus_reset();
        wr_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd_slot(b);
            rd_slot(c);
            check(b == ID_VAL[i] && c == !ID_VAL[i], "R8 bit/complement",
                  {b, c}, {ID_VAL[i], !ID_VAL[i]});
            wr_slot(ID_VAL[i]);
        end
        check(select_o == 1'b1, "R8 search selects", select_o, 1);

        // R9: wrong direction at bit 6; bit 7 would be sent as 0
        bus_reset();
        wr_byte(8'hF0);
        for (int i = 0; i < 7; i++) begin
            rd_slot(b);
            rd_slot(c);
            wr_slot(i == 6 ? !ID_VAL[i] : ID_VAL[i]);
        end
        rd_slot(b);
        check(b == 1'b1, "R9 dropped out released", b, 1);
        rd_slot(c);
        check(c == 1'b1 && select_o == 1'b0, "R9 dropped out silent",
              {c, select_o}, 2'b10);

        // R10: alarm search, alarm set, one bit pair then silence check absent
        alarm_i = 1'b1;
        bus_reset();
        wr_byte(8'hEC);
        rd_slot(b);
        rd_slot(c);
        check(b == 1'b0 && c == 1'b1, "R10 alarm search pair", {b, c}, 2'b01);
        alarm_i = 1'b0;

        // R11: unknown command then writes of a match stay silent
        bus_reset();
        wr_byte(8'h00);
        for (int i = 0; i < 64; i++) wr_slot(ID_VAL[i]);
        check(select_o == 1'b0, "R11 unknown stays idle", select_o, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule